// File: doc/BRIEF.md
# GF(2^12) Tower-Field Multiplier

This block multiplies two 12-bit elements of GF(2^12). It treats the field as a quadratic extension of GF(2^6): every element is a pair (high, low) of 6-bit GF(64) values standing for high·X + low, with X^2 = X + β and β = 0x21. The GF(64) arithmetic reduces by x^6 + x + 1. A product costs three general GF(64) multiplications (Karatsuba form) plus one multiplication by the constant β.

A second mode provides the step used to build a Reed-Solomon generator sequence. In this mode the block multiplies operand A by the fixed constant 0xE01 and ignores operand B. An A of zero is treated as a special case and yields 1. Operands come with a valid strobe. In the default build the result is registered: it appears one clock later with its own valid flag, and it holds its value while no new operation arrives. A parameter selects a purely combinational build instead.

Top module: `gf4k_mult_unit`

## Requirements
- R1: While reset is asserted and after it is released, before any operation is accepted, `res_valid` is 0 and `product` is 0.
- R2: `res_valid` is 1 in the cycle after a cycle in which `op_valid` was 1, and it is 0 in the cycle after a cycle in which `op_valid` was 0.
- R3: In multiply mode (`gen_step` = 0), `product` equals A·B in GF(2^12). The element A is (A[11:6], A[5:0]) taken as A[11:6]·X + A[5:0], with X^2 = X + 0x21 over GF(64) mod x^6+x+1.
- R4: Multiplication is commutative: A·B and B·A give the same `product`.
- R5: In multiply mode, B = 1 returns A unchanged, and a zero on either operand returns 0.
- R6: In generator-step mode (`gen_step` = 1), an A of 0 gives 1, any other A gives A·0xE01, and `op_b` has no effect on the result.
- R7: `product` keeps its previous value in every cycle that follows a cycle with `op_valid` = 0.
- R8: Operands whose bits 11:6 are zero give the GF(64) product mod x^6+x+1 in bits 5:0, with bits 11:6 zero. For example, 0x20·0x02 = 0x03 and 0x20·0x20 = 0x30.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operands and mode are valid this cycle |
| gen_step | input | 1 | 1: generator step on A; 0: general A·B |
| op_a | input | 12 | Operand A |
| op_b | input | 12 | Operand B (ignored in generator-step mode) |
| res_valid | output | 1 | Result valid, one cycle after `op_valid` |
| product | output | 12 | Registered result |

## Verification
Two things can happen in the same clock edge: the result of one operation is presented, and a new operation in the other mode is captured. The bench provokes this by issuing back-to-back valid operations whose mode is chosen at random on every cycle, with idle gaps inserted now and then. In each cycle it compares `product` with the value predicted for the operation accepted one edge earlier. After each idle gap it checks that the last result is still held. The predictions come from a schoolbook four-product model built on bit-serial GF(64) multiplication, which is a different structure from the Karatsuba datapath.

// File: rtl/gf4k_pkg.sv
package gf4k_pkg;
   // Default tower-field construction: GF(64) mod x^6+x+1, X^2 = X + beta
   localparam int unsigned GF_HALF_W    = 6;
   localparam int unsigned GF_ELEM_W    = 2 * GF_HALF_W;
   localparam logic [GF_HALF_W:0]   GF_RED_POLY  = 7'h43;
   localparam logic [GF_HALF_W-1:0] GF_BETA      = 6'h21;
   localparam logic [GF_ELEM_W-1:0] GF_GEN_CONST = 12'hE01;

   typedef struct packed {
      logic [GF_HALF_W-1:0] hi;
      logic [GF_HALF_W-1:0] lo;
   } gf_pair_t;
endpackage

// File: rtl/gf64_mul.sv
module gf64_mul #(
   parameter int unsigned          W    = gf4k_pkg::GF_HALF_W,
   parameter logic [W:0]           POLY = gf4k_pkg::GF_RED_POLY
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] p
);
   localparam logic [W-1:0] FOLD = POLY[W-1:0];

   // W unrolled shift-and-add stages; overflow past bit W-1 folds back by FOLD
   always_comb begin
      logic [W-1:0] acc;
      logic [W-1:0] sh;
      acc = '0;
      sh  = b;
      for (int i = 0; i < int'(W); i++) begin
         if (a[i]) acc = acc ^ sh;
         sh = sh[W-1] ? ({sh[W-2:0], 1'b0} ^ FOLD) : {sh[W-2:0], 1'b0};
      end
      p = acc;
   end
endmodule

// File: rtl/gf4k_core.sv
module gf4k_core #(
   parameter int unsigned     HALF_W = gf4k_pkg::GF_HALF_W,
   parameter logic [HALF_W:0] POLY   = gf4k_pkg::GF_RED_POLY,
   parameter logic [HALF_W-1:0] BETA = gf4k_pkg::GF_BETA,
   localparam int unsigned    ELEM_W = 2 * HALF_W
) (
   input  logic [ELEM_W-1:0] x,
   input  logic [ELEM_W-1:0] y,
   output logic [ELEM_W-1:0] z
);
   logic [HALF_W-1:0] xh, xl, yh, yl;
   logic [HALF_W-1:0] m_cross, m_low, m_high, m_beta;

   assign xh = x[ELEM_W-1:HALF_W];
   assign xl = x[HALF_W-1:0];
   assign yh = y[ELEM_W-1:HALF_W];
   assign yl = y[HALF_W-1:0];

   gf64_mul #(.W(HALF_W), .POLY(POLY)) i_cross (.a(xh ^ xl), .b(yh ^ yl), .p(m_cross));
   gf64_mul #(.W(HALF_W), .POLY(POLY)) i_low   (.a(xl),      .b(yl),      .p(m_low));
   gf64_mul #(.W(HALF_W), .POLY(POLY)) i_high  (.a(xh),      .b(yh),      .p(m_high));
   gf64_mul #(.W(HALF_W), .POLY(POLY)) i_beta  (.a(m_high),  .b(BETA),    .p(m_beta));

   // Karatsuba recombination: hi = (xh+xl)(yh+yl) + xl*yl ; lo = beta*xh*yh + xl*yl
   assign z = {m_cross ^ m_low, m_beta ^ m_low};
endmodule

// File: rtl/gf4k_step_sel.sv
module gf4k_step_sel #(
   parameter int unsigned          ELEM_W    = gf4k_pkg::GF_ELEM_W,
   parameter logic [ELEM_W-1:0]    GEN_CONST = gf4k_pkg::GF_GEN_CONST
) (
   input  logic              gen_step,
   input  logic [ELEM_W-1:0] a,
   input  logic [ELEM_W-1:0] b,
   input  logic [ELEM_W-1:0] core_z,
   output logic [ELEM_W-1:0] core_y,
   output logic [ELEM_W-1:0] result
);
   localparam logic [ELEM_W-1:0] ONE = ELEM_W'(1);

   assign core_y = gen_step ? GEN_CONST : b;
   assign result = (gen_step && (a == '0)) ? ONE : core_z;
endmodule

// File: rtl/gf4k_mult_unit.sv
module gf4k_mult_unit #(
   parameter int unsigned          HALF_W    = gf4k_pkg::GF_HALF_W,
   parameter logic [HALF_W:0]      RED_POLY  = gf4k_pkg::GF_RED_POLY,
   parameter logic [HALF_W-1:0]    BETA      = gf4k_pkg::GF_BETA,
   parameter logic [2*HALF_W-1:0]  GEN_CONST = gf4k_pkg::GF_GEN_CONST,
   parameter int unsigned          PIPE      = 1,
   localparam int unsigned         ELEM_W    = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic              gen_step,
   input  logic [ELEM_W-1:0] op_a,
   input  logic [ELEM_W-1:0] op_b,
   output logic              res_valid,
   output logic [ELEM_W-1:0] product
);
   // Elaboration-time parameter checks
   if (HALF_W < 2) begin : g_bad_width
      $error("gf4k_mult_unit: HALF_W must be at least 2");
   end
   if (RED_POLY[HALF_W] != 1'b1 || RED_POLY[0] != 1'b1) begin : g_bad_poly
      $error("gf4k_mult_unit: RED_POLY must be monic of degree HALF_W with constant term");
   end
   if (BETA == '0) begin : g_bad_beta
      $error("gf4k_mult_unit: BETA must be non-zero");
   end
   if (PIPE > 1) begin : g_bad_pipe
      $error("gf4k_mult_unit: PIPE must be 0 or 1");
   end

   logic [ELEM_W-1:0] core_y, core_z, result;

   gf4k_step_sel #(.ELEM_W(ELEM_W), .GEN_CONST(GEN_CONST)) i_sel (
      .gen_step (gen_step),
      .a        (op_a),
      .b        (op_b),
      .core_z   (core_z),
      .core_y   (core_y),
      .result   (result)
   );

   gf4k_core #(.HALF_W(HALF_W), .POLY(RED_POLY), .BETA(BETA)) i_core (
      .x (op_a),
      .y (core_y),
      .z (core_z)
   );

   if (PIPE == 1) begin : g_reg
      logic              vld_q;
      logic [ELEM_W-1:0] prod_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q  <= 1'b0;
            prod_q <= '0;
         end else begin
            vld_q <= op_valid;
            if (op_valid) prod_q <= result;
         end
      end
      assign res_valid = vld_q;
      assign product   = prod_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign res_valid  = op_valid;
      assign product    = result;
   end
endmodule

// File: rtl/gf4k_mult_unit_chk.sv
module gf4k_mult_unit_chk #(
   parameter int unsigned ELEM_W = 12,
   parameter int unsigned PIPE   = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic              gen_step,
   input logic [ELEM_W-1:0] op_a,
   input logic [ELEM_W-1:0] op_b,
   input logic              res_valid,
   input logic [ELEM_W-1:0] product
);
   localparam logic [ELEM_W-1:0] ONE = ELEM_W'(1);

   if (PIPE == 1) begin : g_props
      assert_reset_clear_R1: assert property (@(posedge clk)
         !rst_n |=> (!res_valid && product == '0));

      assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
         op_valid |=> res_valid);

      assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !op_valid |=> !res_valid);

      assert_identity_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (op_valid && !gen_step && op_b == ONE) |=> (product == $past(op_a)));

      assert_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (op_valid && !gen_step && (op_a == '0 || op_b == '0)) |=> (product == '0));

      assert_gen_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (op_valid && gen_step && op_a == '0) |=> (product == ONE));

      assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !op_valid |=> $stable(product));
   end
endmodule

bind gf4k_mult_unit gf4k_mult_unit_chk #(.ELEM_W(ELEM_W), .PIPE(PIPE)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .gen_step  (gen_step),
   .op_a      (op_a),
   .op_b      (op_b),
   .res_valid (res_valid),
   .product   (product)
);

// File: tb/test_gf4k_mult_unit.sv
module test_gf4k_mult_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        gen_step = 1'b0;
   logic [11:0] op_a = '0;
   logic [11:0] op_b = '0;
   logic        res_valid;
   logic [11:0] product;

   int n_chk  = 0;
   int n_fail = 0;
   logic [11:0] held = '0;

   always #10 clk = ~clk;

   gf4k_mult_unit i_gf4k_mult_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .gen_step(gen_step),
      .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .product(product)
   );

   // Reference: bit-serial GF(64) via full polynomial product, then reduction
   function automatic logic [5:0] ref64(input logic [5:0] a, input logic [5:0] b);
      logic [10:0] t;
      t = '0;
      for (int i = 0; i < 6; i++) if (b[i]) t = t ^ (11'(a) << i);
      for (int k = 10; k >= 6; k--) if (t[k]) t = t ^ (11'h43 << (k - 6));
      return t[5:0];
   endfunction

   // Reference: schoolbook product with X^2 = X + 0x21
   function automatic logic [11:0] ref4k(input logic [11:0] a, input logic [11:0] b);
      logic [5:0] hh, hl, lh, ll;
      hh = ref64(a[11:6], b[11:6]);
      hl = ref64(a[11:6], b[5:0]);
      lh = ref64(a[5:0],  b[11:6]);
      ll = ref64(a[5:0],  b[5:0]);
      return {hh ^ hl ^ lh, ref64(hh, 6'h21) ^ ll};
   endfunction

   function automatic logic [11:0] expect_of(input logic m, input logic [11:0] a, input logic [11:0] b);
      if (m) return (a == 12'h000) ? 12'h001 : ref4k(a, 12'hE01);
      return ref4k(a, b);
   endfunction

   task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %03h expected %03h", tag, act, exp);
      end
   endtask

   // Drive at negedge, result checked at the following negedge
   task automatic cycle(input string tag, input logic v, input logic m,
                        input logic [11:0] a, input logic [11:0] b);
      logic [11:0] e;
      op_valid = v; gen_step = m; op_a = a; op_b = b;
      @(posedge clk); @(negedge clk);
      if (v) begin
         e = expect_of(m, a, b);
         check({tag, " valid"}, {11'd0, res_valid}, 12'd1);
         check(tag, product, e);
         held = e;
      end else begin
         check({tag, " idle valid"}, {11'd0, res_valid}, 12'd0);
         check({tag, " hold"}, product, held);
      end
   endtask

   initial begin
      #3_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [11:0] p1;
      logic [11:0] ra, rb;
      void'($urandom(32'h5eed_1234));
      // R1: reset state
      @(negedge clk); @(negedge clk);
      check("R1 reset valid", {11'd0, res_valid}, 12'd0);
      check("R1 reset product", product, 12'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 post-release valid", {11'd0, res_valid}, 12'd0);
      check("R1 post-release product", product, 12'd0);

      // R8: low-half-only operands
      cycle("R8 0x20*0x02", 1, 0, 12'h020, 12'h002);
      check("R8 literal 0x03", product, 12'h003);
      cycle("R8 0x20*0x20", 1, 0, 12'h020, 12'h020);
      check("R8 literal 0x30", product, 12'h030);
      // R5: identity and zero
      cycle("R5 a*1", 1, 0, 12'hABC, 12'h001);
      check("R5 identity literal", product, 12'hABC);
      cycle("R5 0*b", 1, 0, 12'h000, 12'h7F3);
      check("R5 zero literal", product, 12'h000);
      cycle("R5 a*0", 1, 0, 12'hFFF, 12'h000);
      // R6: generator step
      cycle("R6 gen zero", 1, 1, 12'h000, 12'h555);
      check("R6 gen zero literal", product, 12'h001);
      cycle("R6 gen one", 1, 1, 12'h001, 12'h3C3);
      check("R6 gen one literal", product, 12'hE01);
      // R7: hold across idle cycles
      cycle("R7 idle", 0, 0, 12'h123, 12'h456);
      cycle("R7 idle mode", 0, 1, 12'h000, 12'h000);
      // R2/R3: max operands
      cycle("R3 fff*fff", 1, 0, 12'hFFF, 12'hFFF);

      // R4: commutativity
      for (int k = 0; k < 40; k++) begin
         ra = 12'($urandom); rb = 12'($urandom);
         cycle("R4 a*b", 1, 0, ra, rb);
         p1 = product;
         cycle("R4 b*a", 1, 0, rb, ra);
         check("R4 commute", product, p1);
      end

      // R6: op_b has no effect in generator mode
      for (int k = 0; k < 20; k++) begin
         ra = 12'($urandom);
         cycle("R6 gen b1", 1, 1, ra, 12'($urandom));
         p1 = product;
         cycle("R6 gen b2", 1, 1, ra, 12'($urandom));
         check("R6 b ignored", product, p1);
      end

      // R2/R3/R6/R7: random back-to-back mixed traffic with gaps
      for (int k = 0; k < 2000; k++) begin
         ra = 12'($urandom); rb = 12'($urandom);
         if (($urandom % 16) == 0) ra = 12'h000;
         if (($urandom % 7) == 0)
            cycle("R7 random idle", 0, 1'($urandom), ra, rb);
         else
            cycle("R3 random", 1, 1'($urandom), ra, rb);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule